// File: doc/BRIEF.md
# Slot Power-Up Sequencer

This block orders slot power, reference clock and port reset for one downstream port of a serial-link switch. A two-bit strap input chooses how the port behaves. A fixed slot has no hot-plug support. Its clock comes up at once, and reset is released when the clock reports stable. If no link partner appears within a training window, the port backs off. A hot-plug slot waits for a power-on request from slot control. It then drives its active-low power enable and waits for power-good, either watched on a pin or assumed present. After that it turns on the reference clock, counts a fixed delay in milliseconds and only then releases reset. Once the port is running, an optional clock-request gate can stop the reference clock while the device does not ask for it.

Intervals are counted on a one-millisecond tick that the surrounding logic supplies. Two parameters set the clock-to-reset delay and the training window, so simulations can use short values. The state code and a done flag are brought out so that edge ordering can be observed.

States and transitions:
- NOMODE goes to FIX_CLK when the captured strap is the fixed code. It goes to OFF when the strap is either hot-plug code.
- In fixed mode, FIX_CLK goes to FIX_TRAIN when the clock is stable. FIX_TRAIN goes to ACTIVE on link-up, or to BACKOFF when the window expires.
- In hot-plug mode, OFF goes to PWR_WAIT on a power request. PWR_WAIT goes to CLK_DLY on power-good, or at once in the no-feedback mode. CLK_DLY goes to ACTIVE when the delay expires.
- Withdrawing the power request takes ACTIVE to DN_RST. It takes PWR_WAIT or CLK_DLY straight to DN_CLK. DN_RST goes to DN_CLK, and DN_CLK goes to OFF.

Top module: `slot_power_seq`

## Requirements
- R1: While the block is in reset, and for as long as the captured strap is 00, the state code is 0 (NOMODE). In that case pwr_en_n is 1, refclk_en is 0, perst_n is 0 and seq_done is 0, whatever the other inputs do.
- R2: The strap is captured on the first clock edge after reset release and held until the next reset. The codes are 01 fixed slot, 10 hot-plug with power-good and 11 hot-plug without feedback. The second edge after release enters state 7 (FIX_CLK) for code 01 or state 1 (OFF) for either hot-plug code.
- R3: In fixed mode pwr_en_n stays 1, and pwr_req and pwr_good have no effect. refclk_en is 1 in state 7. perst_n goes to 1 on the first edge that samples refclk_stable high, entering state 8 (FIX_TRAIN).
- R4: In fixed mode, link_up sampled high in state 8 moves the block to state 4 (ACTIVE) on that edge, with perst_n and refclk_en at 1.
- R5: In fixed mode, if link_up stays low for FIX_TRAIN_MS ticks counted in state 8, the block enters state 9 (BACKOFF). There perst_n and refclk_en are 0, and the block stays in state 9 until reset whatever the other inputs do.
- R6: In hot-plug mode, state 1 keeps every output inactive until pwr_req is sampled high. The next state, 2 (PWR_WAIT), drives pwr_en_n to 0 with refclk_en and perst_n at 0. With code 10 it stays in state 2 while pwr_good is low.
- R7: With code 10, the edge that samples pwr_good high enters state 3 (CLK_DLY), where refclk_en is 1. perst_n rises when state 4 is entered, after exactly CLK_DELAY_MS ticks counted in state 3.
- R8: With code 11, pwr_good is ignored. State 2 lasts exactly one cycle, so refclk_en rises one cycle after pwr_en_n falls, and state 3 then lasts CLK_DELAY_MS ticks.
- R9: In state 4, refclk_en is 0 when clkreq_gate_en is 1 and clkreq_n is 1, and refclk_en is 1 otherwise. Before state 4, clkreq_n has no effect.
- R10: Withdrawing pwr_req in state 4 takes the block through three states, one cycle each. In state 5 (DN_RST) perst_n is 0 while the clock and power stay on. In state 6 (DN_CLK) refclk_en is 0. In state 1 pwr_en_n is 1. Withdrawing it in state 2 or 3 goes to state 6 and then to state 1.
- R11: seq_done is 1 exactly while the state code is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| mode_strap | input | 2 | Strap code, captured after reset |
| pwr_req | input | 1 | Slot-control request to power the slot |
| pwr_good | input | 1 | High when slot power is stable |
| clkreq_n | input | 1 | Active-low clock request from the device |
| clkreq_gate_en | input | 1 | Enables clock-request gating for this port |
| refclk_stable | input | 1 | Reference clock reported stable |
| link_up | input | 1 | Link partner detected |
| pwr_en_n | output | 1 | Active-low slot power enable |
| refclk_en | output | 1 | Reference clock enable |
| perst_n | output | 1 | Active-low port reset |
| state_o | output | 4 | Current state code |
| seq_done | output | 1 | Sequence finished, port running |

## Verification
The hardest situation to reach is a count boundary: the tick that expires a delay must line up with the single cycle in which the timer reaches zero. The bench therefore drives a fixed-rate tick and counts ticks itself in the states where a timer runs, then compares its count with the parameter when the state changes. The power-down chain and the backoff are reached only after a full power-up, so each random trial first runs through a complete sequence. Power-good delays and clock-request patterns are random, and the request is withdrawn at several points of the sequence.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    typedef enum logic [1:0] {
        MODE_NONE    = 2'b00,
        MODE_FIXED   = 2'b01,
        MODE_HP_FB   = 2'b10,
        MODE_HP_NOFB = 2'b11
    } slot_mode_e;

    typedef enum logic [3:0] {
        ST_NOMODE    = 4'd0,
        ST_OFF       = 4'd1,
        ST_PWR_WAIT  = 4'd2,
        ST_CLK_DLY   = 4'd3,
        ST_ACTIVE    = 4'd4,
        ST_DN_RST    = 4'd5,
        ST_DN_CLK    = 4'd6,
        ST_FIX_CLK   = 4'd7,
        ST_FIX_TRAIN = 4'd8,
        ST_BACKOFF   = 4'd9
    } seq_state_e;

    typedef struct packed {
        logic pwr_en_n;
        logic refclk_en;
        logic perst_n;
        logic done;
        logic gate_win;
    } seq_out_t;

    function automatic logic is_hotplug(slot_mode_e m);
        return (m == MODE_HP_FB) || (m == MODE_HP_NOFB);
    endfunction

endpackage

// File: rtl/slot_seq_strap.sv
module slot_seq_strap
    import slot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap,
    output slot_mode_e mode,
    output logic       mode_valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= MODE_NONE;
            mode_valid <= 1'b0;
        end else if (!mode_valid) begin
            mode       <= slot_mode_e'(strap);
            mode_valid <= 1'b1;
        end
    end

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |=> ($stable(mode) && mode_valid));

endmodule

// File: rtl/slot_seq_timer.sv
module slot_seq_timer #(
    parameter int unsigned CLK_DELAY_MS = 100,
    parameter int unsigned FIX_TRAIN_MS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_train,
    input  logic run,
    input  logic tick,
    output logic expired
);

    localparam int unsigned MAX_MS = (CLK_DELAY_MS > FIX_TRAIN_MS) ? CLK_DELAY_MS : FIX_TRAIN_MS;
    localparam int unsigned CW     = $clog2(MAX_MS + 1);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (start) begin
            cnt   <= sel_train ? CW'(FIX_TRAIN_MS) : CW'(CLK_DELAY_MS);
            armed <= 1'b1;
        end else if (!run) begin
            armed <= 1'b0;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = armed && run && (cnt == '0);

    // R7
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && run && !start && tick && (cnt != '0)) |=> (cnt == $past(cnt) - CW'(1)));

    // R5
    no_early_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && run && !start && !tick) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
    import slot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_mode_e mode,
    input  logic       mode_valid,
    input  logic       pwr_req,
    input  logic       pwr_good,
    input  logic       refclk_stable,
    input  logic       link_up,
    input  logic       tmr_expired,
    output seq_state_e state_q,
    output logic       tmr_start,
    output logic       tmr_sel_train,
    output logic       tmr_run,
    output seq_out_t   outs
);

    seq_state_e state_d;
    logic       hp;
    logic       power_ok;

    assign hp       = is_hotplug(mode);
    assign power_ok = pwr_good || (mode == MODE_HP_NOFB);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NOMODE: begin
                if (mode_valid) begin
                    if (mode == MODE_FIXED) state_d = ST_FIX_CLK;
                    else if (hp)            state_d = ST_OFF;
                end
            end
            ST_OFF: begin
                if (pwr_req) state_d = ST_PWR_WAIT;
            end
            ST_PWR_WAIT: begin
                if (!pwr_req)      state_d = ST_DN_CLK;
                else if (power_ok) state_d = ST_CLK_DLY;
            end
            ST_CLK_DLY: begin
                if (!pwr_req)         state_d = ST_DN_CLK;
                else if (tmr_expired) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (hp && !pwr_req) state_d = ST_DN_RST;
            end
            ST_DN_RST:  state_d = ST_DN_CLK;
            ST_DN_CLK:  state_d = ST_OFF;
            ST_FIX_CLK: begin
                if (refclk_stable) state_d = ST_FIX_TRAIN;
            end
            ST_FIX_TRAIN: begin
                if (link_up)          state_d = ST_ACTIVE;
                else if (tmr_expired) state_d = ST_BACKOFF;
            end
            ST_BACKOFF: state_d = ST_BACKOFF;
            default:    state_d = ST_NOMODE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NOMODE;
        else        state_q <= state_d;
    end

    // timer control
    assign tmr_start     = (state_d != state_q) &&
                           ((state_d == ST_CLK_DLY) || (state_d == ST_FIX_TRAIN));
    assign tmr_sel_train = (state_d == ST_FIX_TRAIN);
    assign tmr_run       = (state_q == ST_CLK_DLY) || (state_q == ST_FIX_TRAIN);

    // outputs
    always_comb begin
        outs = '{pwr_en_n: 1'b1, refclk_en: 1'b0, perst_n: 1'b0, done: 1'b0, gate_win: 1'b0};
        unique case (state_q)
            ST_NOMODE, ST_OFF, ST_BACKOFF: ;
            ST_PWR_WAIT: outs.pwr_en_n = 1'b0;
            ST_CLK_DLY: begin
                outs.pwr_en_n  = 1'b0;
                outs.refclk_en = 1'b1;
            end
            ST_ACTIVE: begin
                outs.pwr_en_n  = !hp;
                outs.refclk_en = 1'b1;
                outs.perst_n   = 1'b1;
                outs.done      = 1'b1;
                outs.gate_win  = 1'b1;
            end
            ST_DN_RST: begin
                outs.pwr_en_n  = 1'b0;
                outs.refclk_en = 1'b1;
            end
            ST_DN_CLK:  outs.pwr_en_n = 1'b0;
            ST_FIX_CLK: outs.refclk_en = 1'b1;
            ST_FIX_TRAIN: begin
                outs.refclk_en = 1'b1;
                outs.perst_n   = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    pwr_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(outs.pwr_en_n) |-> (($past(outs.refclk_en) == 1'b0) && !outs.perst_n));

    // R10
    clk_off_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(outs.refclk_en) && hp) |-> ($past(outs.perst_n) == 1'b0));

    // R3
    fixed_no_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIXED) |-> outs.pwr_en_n);

    // R1
    nomode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && (mode == MODE_NONE)) |->
            ((state_q == ST_NOMODE) && outs.pwr_en_n && !outs.refclk_en && !outs.perst_n));

    // R7
    rst_release_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(outs.perst_n) && hp) |-> ($past(outs.refclk_en) && !outs.pwr_en_n));

    // R5
    backoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF) |=> (state_q == ST_BACKOFF));

endmodule

// File: rtl/slot_power_seq.sv
module slot_power_seq
    import slot_seq_pkg::*;
#(
    parameter int unsigned CLK_DELAY_MS = 100,
    parameter int unsigned FIX_TRAIN_MS = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic [1:0] mode_strap,
    input  logic       pwr_req,
    input  logic       pwr_good,
    input  logic       clkreq_n,
    input  logic       clkreq_gate_en,
    input  logic       refclk_stable,
    input  logic       link_up,
    output logic       pwr_en_n,
    output logic       refclk_en,
    output logic       perst_n,
    output logic [3:0] state_o,
    output logic       seq_done
);

    slot_mode_e mode;
    logic       mode_valid;
    seq_state_e state_q;
    logic       tmr_start;
    logic       tmr_sel_train;
    logic       tmr_run;
    logic       tmr_expired;
    seq_out_t   outs;
    logic       clk_gated_off;

    slot_seq_strap u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (mode_strap),
        .mode       (mode),
        .mode_valid (mode_valid)
    );

    slot_seq_timer #(
        .CLK_DELAY_MS (CLK_DELAY_MS),
        .FIX_TRAIN_MS (FIX_TRAIN_MS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tmr_start),
        .sel_train (tmr_sel_train),
        .run       (tmr_run),
        .tick      (ms_tick),
        .expired   (tmr_expired)
    );

    slot_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .mode_valid    (mode_valid),
        .pwr_req       (pwr_req),
        .pwr_good      (pwr_good),
        .refclk_stable (refclk_stable),
        .link_up       (link_up),
        .tmr_expired   (tmr_expired),
        .state_q       (state_q),
        .tmr_start     (tmr_start),
        .tmr_sel_train (tmr_sel_train),
        .tmr_run       (tmr_run),
        .outs          (outs)
    );

    // clock-request gate, active only once the port is running
    assign clk_gated_off = outs.gate_win && clkreq_gate_en && clkreq_n;

    assign pwr_en_n  = outs.pwr_en_n;
    assign refclk_en = outs.refclk_en && !clk_gated_off;
    assign perst_n   = outs.perst_n;
    assign seq_done  = outs.done;
    assign state_o   = state_q;

    // R9
    gate_only_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outs.refclk_en && !refclk_en) |-> perst_n);

    // R11
    done_means_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (perst_n && (state_o == 4'd4)));

endmodule

// File: tb/tb_slot_power_seq.sv
`timescale 1ns/1ps
module tb_slot_power_seq;

    localparam int DLY  = 5;
    localparam int TRN  = 7;
    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ms_tick = 1'b0;
    logic [1:0] mode_strap;
    logic       pwr_req, pwr_good, clkreq_n, clkreq_gate_en, refclk_stable, link_up;
    logic       pwr_en_n, refclk_en, perst_n, seq_done;
    logic [3:0] state_o;

    int total = 0;
    int fails = 0;
    int dly_ticks = 0;
    int trn_ticks = 0;

    always #4 clk = ~clk;

    slot_power_seq #(.CLK_DELAY_MS(DLY), .FIX_TRAIN_MS(TRN)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .mode_strap(mode_strap),
        .pwr_req(pwr_req), .pwr_good(pwr_good), .clkreq_n(clkreq_n),
        .clkreq_gate_en(clkreq_gate_en), .refclk_stable(refclk_stable),
        .link_up(link_up), .pwr_en_n(pwr_en_n), .refclk_en(refclk_en),
        .perst_n(perst_n), .state_o(state_o), .seq_done(seq_done)
    );

    initial begin : tick_gen
        int div = 0;
        forever begin
            @(posedge clk); #1;
            ms_tick = (div == 0);
            div = (div + 1) % TDIV;
        end
    end

    always @(negedge clk) begin
        if (ms_tick && refclk_en && !perst_n && !pwr_en_n) dly_ticks++;
        if (ms_tick && state_o == 4'd8) trn_ticks++;
    end

    function automatic bit exp_refclk(bit gate, bit creq_n);
        return !(gate && creq_n);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk_outs(input string req, input int st, input bit pe_n, input bit rc, input bit pr_n);
        chk(state_o == st[3:0], {req, " state"}, state_o, st);
        chk(pwr_en_n == pe_n, {req, " pwr_en_n"}, pwr_en_n, pe_n);
        chk(refclk_en == rc, {req, " refclk_en"}, refclk_en, rc);
        chk(perst_n == pr_n, {req, " perst_n"}, perst_n, pr_n);
    endtask

    task automatic wait_state(input int st, input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i < maxc; i++) begin
            if (state_o == st[3:0]) begin ok = 1; break; end
            step();
        end
    endtask

    task automatic do_reset(input logic [1:0] strap);
        rst_n = 1'b0;
        mode_strap = strap;
        pwr_req = 0; pwr_good = 0; clkreq_n = 0; clkreq_gate_en = 0;
        refclk_stable = 0; link_up = 0;
        step(3);
        // R1 reset state
        chk_outs("R1 reset", 0, 1, 0, 0);
        chk(seq_done == 0, "R1 reset seq_done", seq_done, 0);
        rst_n = 1'b1;
        step();
    endtask

    // hot-plug power-up then power-down; returns after OFF reached
    task automatic hp_cycle(input bit fb, input int pg_wait);
        bit ok;
        int base;
        bit gate;
        gate = $urandom_range(0, 1);
        clkreq_gate_en = gate;
        clkreq_n = 1;
        for (int i = 0; i < $urandom_range(1, 6); i++) begin
            pwr_good = $urandom_range(0, 1);
            step();
            // R6 idle while no request
            chk_outs("R6 off", 1, 1, 0, 0);
        end
        pwr_good = 0;
        pwr_req = 1;
        base = dly_ticks;
        step();
        // R6 power enable first
        chk_outs("R6 pwr_wait", 2, 0, 0, 0);
        if (fb) begin
            for (int i = 0; i < pg_wait; i++) begin
                step();
                chk_outs("R6 wait power-good", 2, 0, 0, 0);
            end
            pwr_good = 1;
            step();
            // R7 clock on after power-good edge; R9 clkreq ignored before release
            chk_outs("R7 clk_dly", 3, 0, 1, 0);
        end else begin
            step();
            // R8 one cycle of power wait, then clock
            chk_outs("R8 clk_dly", 3, 0, 1, 0);
        end
        wait_state(4, 200, ok);
        chk(ok, "R7 reach ACTIVE", state_o, 4);
        chk(dly_ticks - base == DLY, fb ? "R7 delay ticks" : "R8 delay ticks", dly_ticks - base, DLY);
        chk(perst_n == 1 && seq_done == 1, "R11 done in ACTIVE", seq_done, 1);
        for (int i = 0; i < 20; i++) begin
            clkreq_n = $urandom_range(0, 1);
            step();
            // R9 clock-request gate
            chk(refclk_en == exp_refclk(gate, clkreq_n), "R9 gate", refclk_en, exp_refclk(gate, clkreq_n));
        end
        clkreq_n = 0;
        pwr_req = 0;
        step();
        // R10 power-down order
        chk_outs("R10 dn_rst", 5, 0, 1, 0);
        chk(seq_done == 0, "R11 done low", seq_done, 0);
        step();
        chk_outs("R10 dn_clk", 6, 0, 0, 0);
        step();
        chk_outs("R10 off", 1, 1, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        bit ok;
        int base;
        int seed;
        seed = $urandom(32'd4242);

        // R1: no mode selected
        do_reset(2'b00);
        for (int i = 0; i < 30; i++) begin
            pwr_req = $urandom_range(0, 1); pwr_good = $urandom_range(0, 1);
            refclk_stable = $urandom_range(0, 1); link_up = $urandom_range(0, 1);
            step();
            chk_outs("R1 nomode", 0, 1, 0, 0);
        end

        // R2/R3/R4: fixed mode, strap changed after capture
        do_reset(2'b01);
        mode_strap = 2'b10;
        step();
        chk_outs("R2 fixed entry", 7, 1, 1, 0);
        pwr_req = 1; pwr_good = 1;
        for (int i = 0; i < $urandom_range(2, 8); i++) begin
            step();
            // R3 power and request ignored
            chk_outs("R3 fix_clk", 7, 1, 1, 0);
        end
        refclk_stable = 1;
        step();
        chk_outs("R3 release", 8, 1, 1, 1);
        step(2);
        link_up = 1;
        step();
        chk_outs("R4 active", 4, 1, 1, 1);
        chk(seq_done == 1, "R11 fixed done", seq_done, 1);
        pwr_req = 0;
        step(3);
        chk_outs("R4 stays active", 4, 1, 1, 1);

        // R5: training timeout
        do_reset(2'b01);
        refclk_stable = 1;
        base = trn_ticks;
        wait_state(9, 200, ok);
        chk(ok, "R5 reach BACKOFF", state_o, 9);
        chk(trn_ticks - base == TRN, "R5 window ticks", trn_ticks - base, TRN);
        chk_outs("R5 backoff", 9, 1, 0, 0);
        for (int i = 0; i < 15; i++) begin
            link_up = $urandom_range(0, 1); pwr_req = $urandom_range(0, 1);
            refclk_stable = $urandom_range(0, 1);
            step();
            chk_outs("R5 sticky", 9, 1, 0, 0);
        end

        // R2/R6/R7/R9/R10: hot-plug with feedback
        do_reset(2'b10);
        mode_strap = 2'b01;
        step();
        chk_outs("R2 hp entry", 1, 1, 0, 0);
        hp_cycle(1, 0);
        for (int t = 0; t < 5; t++) hp_cycle(1, $urandom_range(1, 15));

        // withdrawal during the delay
        pwr_req = 1; pwr_good = 1;
        step(2);
        chk(state_o == 4'd3, "R10 in clk_dly", state_o, 3);
        pwr_req = 0;
        step();
        chk_outs("R10 abort dn_clk", 6, 0, 0, 0);
        step();
        chk_outs("R10 abort off", 1, 1, 0, 0);

        // R8: hot-plug without feedback
        do_reset(2'b11);
        step();
        for (int t = 0; t < 3; t++) hp_cycle(0, 0);
        pwr_req = 1;
        step();
        pwr_req = 0;
        step();
        chk_outs("R10 abort from pwr_wait", 6, 0, 0, 0);
        step();
        chk_outs("R10 off after abort", 1, 1, 0, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule